// File: doc/BRIEF.md
# Interrupt Message Bridge with Pending Register

This block turns a set of level-sensitive device interrupt lines into single-word register writes, and also contains the receiving side that collects those writes into an interrupt pending register. Each line can be given its own destination address and interrupt number. When a line goes high, the bridge issues a write whose word is `0x100 | number`. When the line drops and its clear option is enabled, the bridge issues a second write with bit 8 at zero, so that the remote pending bit follows the line level.

Edges are found by comparing each line with its value one cycle earlier. They wait in a short per-line queue, so none is lost while the outgoing port is stalled. A fixed-priority arbiter picks the next event and presents it on a registered valid/ready write port.

The receiver decodes writes that arrive at its pending-set address. This address is 0x90 or 0x80, chosen by a parameter. Software can clear pending bits with a write-one-to-clear strobe. Two per-CPU mask registers gate the pending bits onto two CPU interrupt outputs.

Top module: `irq_msg_bridge`

## Requirements
- R1: While reset is applied and after it is released, `msg_valid`, `pending` and `cpu_irq` are all zero until a message is written.
- R2: A low-to-high change on `irq_in[i]` produces one write with `msg_addr` equal to line i's configured destination and `msg_data` equal to 0x100 OR the configured number (bits 15..9 zero).
- R3: A high-to-low change on `irq_in[i]` produces one write of `msg_data` equal to the number with bit 8 at zero, only when line i's clear option is set. Otherwise it produces no write.
- R4: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold their values.
- R5: While the port is stalled, each line keeps up to four events (QD) in arrival order, and they are later sent in that order.
- R6: When several lines have events waiting, the line with the lowest index is sent first.
- R7: A receive write to the pending-set address with bits 15..9 zero and a number below N_INT does the following: if bit 8 is 1 it sets `pending[number]`, and if bit 8 is 0 it clears that bit. Writes to any other address leave `pending` unchanged.
- R8: The pending-set address is 0x90 when HUB_SEL=1 (default) and 0x80 when HUB_SEL=0. With the default, a write to 0x80 has no effect.
- R9: `sw_clr_we` clears every pending bit set in `sw_clr_mask`. If a receive write sets the same bit in the same cycle, the bit ends up set.
- R10: `cpu_irq[c]` is high exactly when some bit is set in both `pending` and mask register c. Mask c is loaded from `mask_wdata` when `mask_we[c]` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_DEV | Device interrupt levels |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | clog2(N_DEV) | Line being configured |
| cfg_dst | input | ADDR_W | Destination address for the line |
| cfg_num | input | clog2(N_INT) | Interrupt number for the line |
| cfg_clr_en | input | 1 | Send clear message on falling level |
| msg_valid | output | 1 | Outgoing write present |
| msg_ready | input | 1 | Outgoing write accepted |
| msg_addr | output | ADDR_W | Outgoing write address |
| msg_data | output | 16 | Outgoing write word |
| rx_valid | input | 1 | Incoming write strobe |
| rx_addr | input | ADDR_W | Incoming write address |
| rx_data | input | 16 | Incoming write word |
| sw_clr_we | input | 1 | Software clear strobe |
| sw_clr_mask | input | N_INT | Pending bits to clear |
| mask_we | input | 2 | Per-CPU mask write strobes |
| mask_wdata | input | N_INT | Mask value to load |
| pending | output | N_INT | Interrupt pending register |
| cpu_irq | output | 2 | Per-CPU interrupt outputs |

## Verification
The assertions assume that no line produces more than QD events while its queue cannot drain. The stimulus respects this by never toggling one line more than four times while `msg_ready` is held low. They also assume one receive write per cycle with a well-formed word. Every toggle of a line is held for at least one full clock, so each edge is sampled separately. Receive traffic is driven either directly by the bench or by looping accepted messages back, and never both at once.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;
    localparam int MSG_DW  = 16;
    localparam int SET_BIT = 8;
    localparam int NUM_W   = 8;

    typedef enum logic {EV_CLR = 1'b0, EV_SET = 1'b1} ev_kind_e;

    function automatic logic [MSG_DW-1:0] msg_word(ev_kind_e kind, logic [NUM_W-1:0] num);
        logic [MSG_DW-1:0] w;
        w = '0;
        w[NUM_W-1:0] = num;
        w[SET_BIT] = (kind == EV_SET);
        return w;
    endfunction
endpackage

// File: rtl/irq_evt_queue.sv
module irq_evt_queue
    import irq_msg_pkg::*;
#(
    parameter int QD = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     lvl,
    input  logic     clr_en,
    input  logic     pop,
    output logic     nonempty,
    output ev_kind_e head,
    output logic     push,
    output logic     full
);
    localparam int CW = $clog2(QD + 1);

    logic            lvl_q;
    logic [CW-1:0]   cnt;
    logic [QD-1:0]   kinds;
    logic            rise, fall, accept;
    logic [CW-1:0]   wr_idx;

    always_comb begin
        rise     = lvl & ~lvl_q;
        fall     = ~lvl & lvl_q;
        push     = rise | (fall & clr_en);
        full     = (cnt == CW'(QD));
        accept   = push & (~full | pop);
        wr_idx   = pop ? cnt - CW'(1) : cnt;
        nonempty = (cnt != '0);
        head     = ev_kind_e'(kinds[0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= 1'b0;
            cnt   <= '0;
            kinds <= '0;
        end else begin
            lvl_q <= lvl;
            cnt   <= cnt - CW'(pop) + CW'(accept);
            for (int i = 0; i < QD; i++) begin
                if (accept && wr_idx == CW'(i))
                    kinds[i] <= rise;
                else if (pop && i < QD - 1)
                    kinds[i] <= kinds[i + 1];
            end
        end
    end
endmodule

// File: rtl/irq_msg_arb.sv
module irq_msg_arb
    import irq_msg_pkg::*;
#(
    parameter int N_DEV  = 4,
    parameter int ADDR_W = 16,
    parameter int IW     = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [N_DEV-1:0]              nonempty,
    input  ev_kind_e                      heads [N_DEV],
    input  logic [N_DEV-1:0][ADDR_W-1:0]  dst,
    input  logic [N_DEV-1:0][IW-1:0]      num,
    input  logic                          msg_ready,
    output logic [N_DEV-1:0]              pop,
    output logic                          msg_valid,
    output logic [ADDR_W-1:0]             msg_addr,
    output logic [MSG_DW-1:0]             msg_data
);
    localparam int SW = (N_DEV > 1) ? $clog2(N_DEV) : 1;

    logic [SW-1:0] sel;
    logic          load;

    always_comb begin
        sel = '0;
        for (int i = N_DEV - 1; i >= 0; i--)
            if (nonempty[i]) sel = SW'(i);
        load = (~msg_valid | msg_ready) & (|nonempty);
        pop  = '0;
        if (load) pop[sel] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid <= 1'b0;
            msg_addr  <= '0;
            msg_data  <= '0;
        end else if (load) begin
            msg_valid <= 1'b1;
            msg_addr  <= dst[sel];
            msg_data  <= msg_word(heads[sel], NUM_W'(num[sel]));
        end else if (msg_ready) begin
            msg_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_pend_rx.sv
module irq_pend_rx
    import irq_msg_pkg::*;
#(
    parameter int N_INT   = 8,
    parameter int ADDR_W  = 16,
    parameter int SET_OFF = 'h90
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [ADDR_W-1:0] rx_addr,
    input  logic [MSG_DW-1:0] rx_data,
    input  logic              sw_clr_we,
    input  logic [N_INT-1:0]  sw_clr_mask,
    input  logic [1:0]        mask_we,
    input  logic [N_INT-1:0]  mask_wdata,
    output logic [N_INT-1:0]  pending,
    output logic [1:0]        cpu_irq
);
    logic [N_INT-1:0] mask_r [2];
    logic [N_INT-1:0] onehot, set_vec, clr_vec;
    logic [NUM_W-1:0] rx_num;
    logic             hit;

    always_comb begin
        rx_num = rx_data[NUM_W-1:0];
        hit = rx_valid && rx_addr == ADDR_W'(SET_OFF)
              && rx_data[MSG_DW-1:SET_BIT+1] == '0
              && int'(rx_num) < N_INT;
        onehot = '0;
        for (int i = 0; i < N_INT; i++)
            if (rx_num == NUM_W'(i)) onehot[i] = 1'b1;
        set_vec = (hit && rx_data[SET_BIT])  ? onehot : '0;
        clr_vec = ((hit && !rx_data[SET_BIT]) ? onehot : '0)
                | (sw_clr_we ? sw_clr_mask : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) pending <= '0;
        else     pending <= (pending & ~clr_vec) | set_vec;
    end

    for (genvar c = 0; c < 2; c++) begin : g_cpu
        always_ff @(posedge clk) begin
            if (rst)             mask_r[c] <= '0;
            else if (mask_we[c]) mask_r[c] <= mask_wdata;
        end
        assign cpu_irq[c] = |(pending & mask_r[c]);
    end
endmodule

// File: rtl/irq_msg_bridge.sv
module irq_msg_bridge
    import irq_msg_pkg::*;
#(
    parameter int N_DEV   = 4,
    parameter int N_INT   = 8,
    parameter int ADDR_W  = 16,
    parameter int QD      = 4,
    parameter bit HUB_SEL = 1'b1
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [N_DEV-1:0]                  irq_in,
    input  logic                              cfg_we,
    input  logic [$clog2(N_DEV)-1:0]          cfg_sel,
    input  logic [ADDR_W-1:0]                 cfg_dst,
    input  logic [$clog2(N_INT)-1:0]          cfg_num,
    input  logic                              cfg_clr_en,
    output logic                              msg_valid,
    input  logic                              msg_ready,
    output logic [ADDR_W-1:0]                 msg_addr,
    output logic [MSG_DW-1:0]                 msg_data,
    input  logic                              rx_valid,
    input  logic [ADDR_W-1:0]                 rx_addr,
    input  logic [MSG_DW-1:0]                 rx_data,
    input  logic                              sw_clr_we,
    input  logic [N_INT-1:0]                  sw_clr_mask,
    input  logic [1:0]                        mask_we,
    input  logic [N_INT-1:0]                  mask_wdata,
    output logic [N_INT-1:0]                  pending,
    output logic [1:0]                        cpu_irq
);
    localparam int IW      = $clog2(N_INT);
    localparam int SET_OFF = HUB_SEL ? 'h90 : 'h80;

    logic [N_DEV-1:0][ADDR_W-1:0] dst_r;
    logic [N_DEV-1:0][IW-1:0]     num_r;
    logic [N_DEV-1:0]             clr_en_r;
    logic [N_DEV-1:0]             q_nonempty, q_pop, q_push, q_full;
    ev_kind_e                     q_head [N_DEV];

    always_ff @(posedge clk) begin
        if (rst) begin
            dst_r    <= '0;
            num_r    <= '0;
            clr_en_r <= '0;
        end else if (cfg_we) begin
            dst_r[cfg_sel]    <= cfg_dst;
            num_r[cfg_sel]    <= cfg_num;
            clr_en_r[cfg_sel] <= cfg_clr_en;
        end
    end

    for (genvar d = 0; d < N_DEV; d++) begin : g_line
        irq_evt_queue #(.QD(QD)) u_q (
            .clk(clk), .rst(rst), .lvl(irq_in[d]), .clr_en(clr_en_r[d]),
            .pop(q_pop[d]), .nonempty(q_nonempty[d]), .head(q_head[d]),
            .push(q_push[d]), .full(q_full[d])
        );
    end

    irq_msg_arb #(.N_DEV(N_DEV), .ADDR_W(ADDR_W), .IW(IW)) u_arb (
        .clk(clk), .rst(rst), .nonempty(q_nonempty), .heads(q_head),
        .dst(dst_r), .num(num_r), .msg_ready(msg_ready), .pop(q_pop),
        .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data)
    );

    irq_pend_rx #(.N_INT(N_INT), .ADDR_W(ADDR_W), .SET_OFF(SET_OFF)) u_rx (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_addr(rx_addr),
        .rx_data(rx_data), .sw_clr_we(sw_clr_we), .sw_clr_mask(sw_clr_mask),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .pending(pending),
        .cpu_irq(cpu_irq)
    );
endmodule

// File: rtl/irq_msg_bridge_chk.sv
module irq_msg_bridge_chk
    import irq_msg_pkg::*;
#(
    parameter int N_DEV   = 4,
    parameter int N_INT   = 8,
    parameter int ADDR_W  = 16,
    parameter bit HUB_SEL = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              msg_valid,
    input logic              msg_ready,
    input logic [ADDR_W-1:0] msg_addr,
    input logic [MSG_DW-1:0] msg_data,
    input logic              rx_valid,
    input logic [ADDR_W-1:0] rx_addr,
    input logic [MSG_DW-1:0] rx_data,
    input logic              sw_clr_we,
    input logic [N_INT-1:0]  sw_clr_mask,
    input logic [N_INT-1:0]  pending,
    input logic [1:0]        cpu_irq,
    input logic [N_DEV-1:0]  q_push,
    input logic [N_DEV-1:0]  q_full,
    input logic [N_DEV-1:0]  q_pop
);
    localparam int IW      = $clog2(N_INT);
    localparam int SET_OFF = HUB_SEL ? 'h90 : 'h80;

    logic seen = 1'b0;
    logic rx_hit, rx_set, rx_clr;
    always_ff @(posedge clk) seen <= 1'b1;

    assign rx_hit = rx_valid && rx_addr == ADDR_W'(SET_OFF);
    assign rx_set = rx_hit && (rx_data >> IW) == MSG_DW'(256 >> IW);
    assign rx_clr = rx_hit && (rx_data >> IW) == '0;

    AST_RESET_IDLE: assert property (@(posedge clk)
        (seen && $past(rst)) |-> (!msg_valid && pending == '0)); // R1
    AST_MSG_FORMAT: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> msg_data[MSG_DW-1:SET_BIT+1] == '0); // R2
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data))); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (q_push & q_full & ~q_pop) == '0); // R5
    AST_ONE_POP: assert property (@(posedge clk) disable iff (rst)
        $onehot0(q_pop)); // R6
    AST_SET_BIT: assert property (@(posedge clk) disable iff (rst)
        rx_set |=> pending[$past(rx_data[IW-1:0])]); // R7
    AST_CLR_BIT: assert property (@(posedge clk) disable iff (rst)
        rx_clr |=> !pending[$past(rx_data[IW-1:0])]); // R7
    AST_SW_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (sw_clr_we && !rx_valid) |=> (pending & $past(sw_clr_mask)) == '0); // R9
    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
        (|cpu_irq) |-> (pending != '0)); // R10
endmodule

bind irq_msg_bridge irq_msg_bridge_chk #(
    .N_DEV(N_DEV), .N_INT(N_INT), .ADDR_W(ADDR_W), .HUB_SEL(HUB_SEL)
) u_chk (
    .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data), .rx_valid(rx_valid),
    .rx_addr(rx_addr), .rx_data(rx_data), .sw_clr_we(sw_clr_we),
    .sw_clr_mask(sw_clr_mask), .pending(pending), .cpu_irq(cpu_irq),
    .q_push(q_push), .q_full(q_full), .q_pop(q_pop)
);

// File: tb/irq_msg_bridge_bench.sv
`timescale 1ns/1ps
module irq_msg_bridge_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  irq_in = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_dst = '0;
    logic [2:0]  cfg_num = '0;
    logic        cfg_clr_en = 1'b0;
    logic        msg_valid, msg_ready = 1'b0;
    logic [15:0] msg_addr, msg_data;
    logic        loop = 1'b0;
    logic        tb_rx_valid = 1'b0;
    logic [15:0] tb_rx_addr = '0, tb_rx_data = '0;
    logic        rx_valid;
    logic [15:0] rx_addr, rx_data;
    logic        sw_clr_we = 1'b0;
    logic [7:0]  sw_clr_mask = '0;
    logic [1:0]  mask_we = '0;
    logic [7:0]  mask_wdata = '0;
    logic [7:0]  pending;
    logic [1:0]  cpu_irq;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    always_comb begin
        rx_valid = loop ? (msg_valid && msg_ready) : tb_rx_valid;
        rx_addr  = loop ? msg_addr : tb_rx_addr;
        rx_data  = loop ? msg_data : tb_rx_data;
    end

    irq_msg_bridge u_irq_msg_bridge (
        .clk(clk), .rst(rst), .irq_in(irq_in), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_dst(cfg_dst), .cfg_num(cfg_num), .cfg_clr_en(cfg_clr_en),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
        .msg_data(msg_data), .rx_valid(rx_valid), .rx_addr(rx_addr),
        .rx_data(rx_data), .sw_clr_we(sw_clr_we), .sw_clr_mask(sw_clr_mask),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .pending(pending),
        .cpu_irq(cpu_irq)
    );

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_valid();
        for (int k = 0; k < 30 && !msg_valid; k++) @(negedge clk);
    endtask

    task automatic take(logic [15:0] ea, logic [15:0] ed, string tag);
        wait_valid();
        chk(msg_valid == 1'b1, {tag, " valid"}, 32'(msg_valid), 1);
        chk(msg_addr == ea, {tag, " addr"}, 32'(msg_addr), 32'(ea));
        chk(msg_data == ed, {tag, " data"}, 32'(msg_data), 32'(ed));
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic cfg(logic [1:0] s, logic [15:0] d, logic [2:0] n, logic c);
        cfg_we = 1'b1; cfg_sel = s; cfg_dst = d; cfg_num = n; cfg_clr_en = c;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic drive(bit do_rx, logic [15:0] a, logic [15:0] d, bit do_sw, logic [7:0] m);
        tb_rx_valid = do_rx; tb_rx_addr = a; tb_rx_data = d;
        sw_clr_we = do_sw; sw_clr_mask = m;
        @(negedge clk);
        tb_rx_valid = 1'b0; sw_clr_we = 1'b0;
    endtask

    task automatic t_reset();
        cycles(3);
        chk(msg_valid == 0 && pending == 0 && cpu_irq == 0, "R1 during reset",
            {msg_valid, pending, cpu_irq}, 0);
        rst = 1'b0;
        cycles(2);
        chk(msg_valid == 0 && pending == 0 && cpu_irq == 0, "R1 after reset",
            {msg_valid, pending, cpu_irq}, 0);
    endtask

    task automatic t_rise_stall();
        irq_in[0] = 1'b1;
        wait_valid();
        chk(msg_valid && msg_addr == 16'h0090 && msg_data == 16'h0103, "R2 rise msg",
            {msg_addr, msg_data}, 32'h00900103);
        cycles(3);
        chk(msg_valid && msg_addr == 16'h0090 && msg_data == 16'h0103, "R4 held while stalled",
            {msg_addr, msg_data}, 32'h00900103);
        take(16'h0090, 16'h0103, "R4 accept");
    endtask

    task automatic t_fall();
        irq_in[0] = 1'b0;
        take(16'h0090, 16'h0003, "R3 clear msg");
        irq_in[1] = 1'b1;
        take(16'h1234, 16'h0105, "R2 line1 rise");
        irq_in[1] = 1'b0;
        cycles(6);
        chk(msg_valid == 0, "R3 no clear when disabled", 32'(msg_valid), 0);
    endtask

    task automatic t_queue();
        irq_in[2] = 1'b1; @(negedge clk);
        irq_in[2] = 1'b0; @(negedge clk);
        irq_in[2] = 1'b1; @(negedge clk);
        irq_in[2] = 1'b0; @(negedge clk);
        take(16'h0090, 16'h0106, "R5 event 1");
        take(16'h0090, 16'h0006, "R5 event 2");
        take(16'h0090, 16'h0106, "R5 event 3");
        take(16'h0090, 16'h0006, "R5 event 4");
        cycles(4);
        chk(msg_valid == 0, "R5 queue drained", 32'(msg_valid), 0);
    endtask

    task automatic t_prio();
        irq_in[3] = 1'b1; irq_in[1] = 1'b1;
        take(16'h1234, 16'h0105, "R6 lower index first");
        take(16'h0040, 16'h0107, "R6 higher index next");
        irq_in[3] = 1'b0; irq_in[1] = 1'b0;
        cycles(6);
        chk(msg_valid == 0, "R3 no clears for lines 1,3", 32'(msg_valid), 0);
    endtask

    task automatic t_rx();
        drive(1, 16'h0090, 16'h0104, 0, 0);
        chk(pending == 8'h10, "R7 set bit 4", pending, 8'h10);
        drive(1, 16'h0090, 16'h0102, 0, 0);
        chk(pending == 8'h14, "R7 set bit 2", pending, 8'h14);
        drive(1, 16'h0090, 16'h0004, 0, 0);
        chk(pending == 8'h04, "R7 clear bit 4", pending, 8'h04);
        drive(1, 16'h1234, 16'h0101, 0, 0);
        chk(pending == 8'h04, "R7 other address ignored", pending, 8'h04);
        drive(1, 16'h0080, 16'h0107, 0, 0);
        chk(pending == 8'h04, "R8 alternate offset ignored", pending, 8'h04);
    endtask

    task automatic t_sw();
        drive(0, 0, 0, 1, 8'h04);
        chk(pending == 8'h00, "R9 sw clear", pending, 0);
        drive(1, 16'h0090, 16'h0105, 1, 8'h20);
        chk(pending == 8'h20, "R9 set wins same bit", pending, 8'h20);
        drive(1, 16'h0090, 16'h0101, 1, 8'hFF);
        chk(pending == 8'h02, "R9 clear all but new set", pending, 8'h02);
        drive(0, 0, 0, 1, 8'hFF);
    endtask

    task automatic t_mask();
        mask_we = 2'b01; mask_wdata = 8'h0F; @(negedge clk);
        mask_we = 2'b10; mask_wdata = 8'hF0; @(negedge clk);
        mask_we = 2'b00;
        chk(cpu_irq == 2'b00, "R10 idle", cpu_irq, 0);
        drive(1, 16'h0090, 16'h0106, 0, 0);
        chk(cpu_irq == 2'b10, "R10 cpu1 only", cpu_irq, 2);
        drive(1, 16'h0090, 16'h0101, 0, 0);
        chk(cpu_irq == 2'b11, "R10 both", cpu_irq, 3);
        drive(1, 16'h0090, 16'h0006, 0, 0);
        chk(cpu_irq == 2'b01, "R10 cpu0 only", cpu_irq, 1);
        drive(0, 0, 0, 1, 8'hFF);
        chk(cpu_irq == 2'b00, "R10 cleared", cpu_irq, 0);
    endtask

    task automatic t_loop();
        loop = 1'b1; msg_ready = 1'b1;
        irq_in[0] = 1'b1;
        cycles(8);
        chk(pending == 8'h08, "R2 R7 loop set", pending, 8'h08);
        irq_in[0] = 1'b0;
        cycles(8);
        chk(pending == 8'h00, "R3 R7 loop clear", pending, 0);
        loop = 1'b0; msg_ready = 1'b0;
    endtask

    initial begin
        t_reset();
        cfg(2'd0, 16'h0090, 3'd3, 1'b1);
        cfg(2'd1, 16'h1234, 3'd5, 1'b0);
        cfg(2'd2, 16'h0090, 3'd6, 1'b1);
        cfg(2'd3, 16'h0040, 3'd7, 1'b0);
        t_rise_stall();
        t_fall();
        t_queue();
        t_prio();
        t_rx();
        t_sw();
        t_mask();
        t_loop();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule